// File: doc/BRIEF.md
# Expanding Opcode Instruction Decoder

This block decodes 16-bit instruction words whose opcode length grows as the operand count shrinks. The word is read as four 4-bit fields, most significant first. A field that holds the all-ones code (or, in the second field, one of its two top codes) does not name a register. Instead it hands the decode on to the next field. In this way one word format carries four instruction classes: 15 with three register operands, 14 with two, 31 with one and 16 with none. Each of the 16 registers takes a 4-bit field.

A front-end stage presents a word together with a valid strobe. One clock later the decoder returns the instruction class, an opcode index that counts from zero within that class, and three register slots. Each slot has its own valid bit. Any class can be built with fewer opcodes than its encoding space holds. A word that lands beyond the implemented count is flagged as an unused encoding, so the execution stage can trap it.

Top module: `xop_decoder`

## Requirements
- R1: If bits [15:12] are not 1111, the class is three-address (class code 0). The index is bits [15:12], and slots A, B and C carry bits [11:8], [7:4] and [3:0].
- R2: If bits [15:12] are 1111 and bits [11:8] lie in 0000..1101, the class is two-address (class code 1). The index is bits [11:8], slot A carries bits [7:4] and slot B carries bits [3:0].
- R3: The class is one-address (class code 2) in two cases. If bits [15:8] are 1111 1110, the index is bits [7:4]. If bits [15:8] are 1111 1111 and bits [7:4] lie in 0000..1110, the index is 16 plus bits [7:4]. In both cases slot A carries bits [3:0].
- R4: If bits [15:4] are all ones, the class is zero-address (class code 3), the index is bits [3:0], and no slot is valid.
- R5: A slot's valid bit is set only when the decoded class uses that slot. A slot that is not valid reports register number 0.
- R6: The unused flag is raised when the index is not below the implemented count for its class (parameters NUM_THREE, NUM_TWO, NUM_ONE and NUM_ZERO). When it is raised, all slot valid bits are 0 and the class and index are still reported.
- R7: A word sampled with the strobe high appears on the outputs after exactly one clock, with out_valid high for that one cycle. While the strobe is low, out_valid stays low and the decoded outputs keep their last values, whatever the word input carries.
- R8: During and just after synchronous reset, out_valid is 0 and every decoded output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word strobe |
| in_word | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded result is new this cycle |
| out_class | output | 2 | 0 three-, 1 two-, 2 one-, 3 zero-address |
| out_opidx | output | 5 | Opcode index within the class |
| out_reg_a | output | 4 | Register number in slot A |
| out_reg_a_vld | output | 1 | Slot A in use |
| out_reg_b | output | 4 | Register number in slot B |
| out_reg_b_vld | output | 1 | Slot B in use |
| out_reg_c | output | 4 | Register number in slot C |
| out_reg_c_vld | output | 1 | Slot C in use |
| out_illegal | output | 1 | Unused encoding |

## Verification
The properties assume that in_word carries no unknown bits in any cycle where in_valid is high. They also assume reset is held for at least one clock edge before the first strobe. The stimulus meets both. It holds the strobe low throughout reset and always drives a defined word, including junk words during idle cycles, which also probe the hold behaviour. The bench elaborates the decoder with reduced opcode counts for three classes. This puts unused encodings inside the swept word space next to the escape boundaries.

// File: rtl/xop_pkg.sv
package xop_pkg;
    localparam int WORD_W = 16;
    localparam int FLD_W  = 4;
    localparam int NFLD   = WORD_W / FLD_W;
    localparam int IDX_W  = FLD_W + 1;
    localparam int NSLOT  = NFLD - 1;

    typedef logic [FLD_W-1:0] fld_t;

    localparam fld_t FLD_ESC     = '1;
    localparam fld_t FLD_TWO_END = fld_t'((1 << FLD_W) - 2);

    typedef enum logic [1:0] {
        CLS_THREE = 2'd0,
        CLS_TWO   = 2'd1,
        CLS_ONE   = 2'd2,
        CLS_ZERO  = 2'd3
    } cls_e;

    typedef struct packed {
        fld_t num;
        logic vld;
    } slot_t;

    typedef struct packed {
        cls_e                   cls;
        logic [IDX_W-1:0]       idx;
        slot_t [NSLOT-1:0]      slots;
        logic                   bad;
    } dec_t;

    function automatic slot_t use_slot(input fld_t f);
        slot_t s;
        s.num = f;
        s.vld = 1'b1;
        return s;
    endfunction
endpackage

// File: rtl/xop_fields.sv
module xop_fields
    import xop_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fld_t              fld [NFLD],
    output logic              esc [NFLD-1:1]
);
    for (genvar i = 0; i < NFLD; i++) begin : g_fld
        assign fld[i] = word[i*FLD_W +: FLD_W];
    end

    for (genvar i = 1; i < NFLD; i++) begin : g_esc
        assign esc[i] = (fld[i] == FLD_ESC);
    end
endmodule

// File: rtl/xop_classify.sv
module xop_classify
    import xop_pkg::*;
#(
    parameter int NUM_THREE = 15,
    parameter int NUM_TWO   = 14,
    parameter int NUM_ONE   = 31,
    parameter int NUM_ZERO  = 16
) (
    input  fld_t fld [NFLD],
    input  logic esc [NFLD-1:1],
    output dec_t dec
);
    localparam logic [IDX_W-1:0] ONE_HI_BASE = IDX_W'(1 << FLD_W);

    int limit;

    always_comb begin
        dec   = '0;
        limit = NUM_ZERO;
        if (!esc[3]) begin
            dec.cls      = CLS_THREE;
            dec.idx      = {1'b0, fld[3]};
            dec.slots[0] = use_slot(fld[2]);
            dec.slots[1] = use_slot(fld[1]);
            dec.slots[2] = use_slot(fld[0]);
            limit        = NUM_THREE;
        end else if (fld[2] < FLD_TWO_END) begin
            dec.cls      = CLS_TWO;
            dec.idx      = {1'b0, fld[2]};
            dec.slots[0] = use_slot(fld[1]);
            dec.slots[1] = use_slot(fld[0]);
            limit        = NUM_TWO;
        end else if (!esc[2]) begin
            dec.cls      = CLS_ONE;
            dec.idx      = {1'b0, fld[1]};
            dec.slots[0] = use_slot(fld[0]);
            limit        = NUM_ONE;
        end else if (!esc[1]) begin
            dec.cls      = CLS_ONE;
            dec.idx      = ONE_HI_BASE + {1'b0, fld[1]};
            dec.slots[0] = use_slot(fld[0]);
            limit        = NUM_ONE;
        end else begin
            dec.cls      = CLS_ZERO;
            dec.idx      = {1'b0, fld[0]};
            limit        = NUM_ZERO;
        end

        if (int'(dec.idx) >= limit) begin
            dec.bad   = 1'b1;
            dec.slots = '0;
        end
    end
endmodule

// File: rtl/xop_stage.sv
module xop_stage
    import xop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  dec_t d,
    output dec_t q,
    output logic q_new
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q_new <= 1'b0;
        end else begin
            q_new <= load;
            if (load) begin
                q <= d;
            end
        end
    end
endmodule

// File: rtl/xop_decoder.sv
module xop_decoder
    import xop_pkg::*;
#(
    parameter int NUM_THREE = 15,
    parameter int NUM_TWO   = 14,
    parameter int NUM_ONE   = 31,
    parameter int NUM_ZERO  = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] in_word,
    output logic        out_valid,
    output logic [1:0]  out_class,
    output logic [4:0]  out_opidx,
    output logic [3:0]  out_reg_a,
    output logic        out_reg_a_vld,
    output logic [3:0]  out_reg_b,
    output logic        out_reg_b_vld,
    output logic [3:0]  out_reg_c,
    output logic        out_reg_c_vld,
    output logic        out_illegal
);
    fld_t fld [NFLD];
    logic esc [NFLD-1:1];
    dec_t dec_d;
    dec_t dec_q;

    xop_fields u_fields (
        .word (in_word),
        .fld  (fld),
        .esc  (esc)
    );

    xop_classify #(
        .NUM_THREE (NUM_THREE),
        .NUM_TWO   (NUM_TWO),
        .NUM_ONE   (NUM_ONE),
        .NUM_ZERO  (NUM_ZERO)
    ) u_classify (
        .fld (fld),
        .esc (esc),
        .dec (dec_d)
    );

    xop_stage u_stage (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid),
        .d     (dec_d),
        .q     (dec_q),
        .q_new (out_valid)
    );

    assign out_class     = dec_q.cls;
    assign out_opidx     = dec_q.idx;
    assign out_reg_a     = dec_q.slots[0].num;
    assign out_reg_a_vld = dec_q.slots[0].vld;
    assign out_reg_b     = dec_q.slots[1].num;
    assign out_reg_b_vld = dec_q.slots[1].vld;
    assign out_reg_c     = dec_q.slots[2].num;
    assign out_reg_c_vld = dec_q.slots[2].vld;
    assign out_illegal   = dec_q.bad;
endmodule

// File: rtl/xop_decoder_chk.sv
module xop_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [15:0] in_word,
    input logic        out_valid,
    input logic [1:0]  out_class,
    input logic [4:0]  out_opidx,
    input logic [3:0]  out_reg_a,
    input logic        out_reg_a_vld,
    input logic [3:0]  out_reg_b,
    input logic        out_reg_b_vld,
    input logic [3:0]  out_reg_c,
    input logic        out_reg_c_vld,
    input logic        out_illegal
);
    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_class) && $stable(out_opidx)
                       && $stable(out_illegal)));

    assert_three_slots_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[15:12] != 4'hF) |=>
            (out_class == 2'd0 && out_opidx == {1'b0, $past(in_word[15:12])}));

    assert_two_class_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[15:12] == 4'hF && in_word[11:8] < 4'hE) |=>
            (out_class == 2'd1));

    assert_one_idx_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == 2'd2) |-> (out_opidx < 5'd31 && !out_reg_b_vld));

    assert_zero_noslots_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == 2'd3) |->
            !(out_reg_a_vld || out_reg_b_vld || out_reg_c_vld));

    assert_unused_num_R5: assert property (@(posedge clk) disable iff (rst)
        (!out_reg_c_vld |-> out_reg_c == 4'd0) and
        (!out_reg_b_vld |-> out_reg_b == 4'd0) and
        (!out_reg_a_vld |-> out_reg_a == 4'd0));

    assert_illegal_slots_R6: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> $countones({out_reg_a_vld, out_reg_b_vld, out_reg_c_vld}) == 0);

    assert_reset_R8: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind xop_decoder xop_decoder_chk u_chk (.*);

// File: tb/sim_xop_decoder.sv
`timescale 1ns/1ps
module sim_xop_decoder;
    localparam int N3 = 15;
    localparam int N2 = 12;
    localparam int N1 = 28;
    localparam int N0 = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = 16'h0;
    logic        out_valid;
    logic [1:0]  out_class;
    logic [4:0]  out_opidx;
    logic [3:0]  out_reg_a, out_reg_b, out_reg_c;
    logic        out_reg_a_vld, out_reg_b_vld, out_reg_c_vld, out_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    xop_decoder #(.NUM_THREE(N3), .NUM_TWO(N2), .NUM_ONE(N1), .NUM_ZERO(N0)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_class(out_class), .out_opidx(out_opidx),
        .out_reg_a(out_reg_a), .out_reg_a_vld(out_reg_a_vld),
        .out_reg_b(out_reg_b), .out_reg_b_vld(out_reg_b_vld),
        .out_reg_c(out_reg_c), .out_reg_c_vld(out_reg_c_vld),
        .out_illegal(out_illegal)
    );

    // {class, idx, a, a_v, b, b_v, c, c_v, bad}
    typedef logic [22:0] item_t;
    item_t exp_q[$];
    item_t last_item = '0;

    function automatic item_t model(input logic [15:0] w);
        logic [1:0] c;
        int idx, lim;
        logic [3:0] ra, rb, rc;
        logic va, vb, vc, bad;
        ra = 0; rb = 0; rc = 0; va = 0; vb = 0; vc = 0;
        if (w < 16'hF000) begin            // R1 range
            c = 0; idx = int'(w >> 12); lim = N3;
            ra = w[11:8]; rb = w[7:4]; rc = w[3:0]; va = 1; vb = 1; vc = 1;
        end else if (w < 16'hFE00) begin   // R2 range
            c = 1; idx = int'((w >> 8) & 16'hF); lim = N2;
            ra = w[7:4]; rb = w[3:0]; va = 1; vb = 1;
        end else if (w < 16'hFFF0) begin   // R3 range
            c = 2; idx = int'((w >> 4) & 16'hFF) - 'hE0; lim = N1;
            ra = w[3:0]; va = 1;
        end else begin                     // R4 range
            c = 3; idx = int'(w & 16'hF); lim = N0;
        end
        bad = (idx >= lim);                // R6
        if (bad) begin
            ra = 0; rb = 0; rc = 0; va = 0; vb = 0; vc = 0;
        end
        return {c, 5'(idx), ra, va, rb, vb, rc, vc, bad};
    endfunction

    function automatic item_t sample();
        return {out_class, out_opidx, out_reg_a, out_reg_a_vld, out_reg_b,
                out_reg_b_vld, out_reg_c, out_reg_c_vld, out_illegal};
    endfunction

    function automatic string tag_of(input item_t it);
        if (it[0]) return "R6";
        case (it[22:21])
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input item_t got, input item_t exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s (slots per R5) got=%h expected=%h", tag, got, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R7 got=out_valid expected=no result pending");
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(tag_of(e), sample(), e);
                    last_item = e;
                end
            end else begin
                check("R7 hold", sample(), last_item);
            end
        end
    end

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        exp_q.push_back(model(w));
    endtask

    task automatic idle(input int n, input logic [15:0] junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_word  = junk ^ 16'(i * 16'h1357);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog got=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : driver
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R8: reset state
        checks++;
        if (out_valid !== 1'b0 || sample() !== '0) begin
            fails++;
            $display("FAIL R8 got=%b/%h expected=0/0", out_valid, sample());
        end
        @(negedge clk); rst = 1'b0;
        checks++;
        if (out_valid !== 1'b0 || sample() !== '0) begin
            fails++;
            $display("FAIL R8 got=%b/%h expected=0/0", out_valid, sample());
        end

        // R1 three-address, incl. 1110 boundary
        send(16'h0000); send(16'h1234); send(16'hEABC); send(16'hEFFF);
        idle(3, 16'hFFFF);
        // R2 two-address, first/last legal and unused (R6)
        send(16'hF0AB); send(16'hFB12); send(16'hFC34); send(16'hFD99);
        idle(2, 16'h0F0F);
        // R3 one-address, both escape prefixes
        send(16'hFE5A); send(16'hFE03); send(16'hFEF3); send(16'hFF07);
        send(16'hFFB1); send(16'hFFC1); send(16'hFFE9);
        idle(2, 16'hAAAA);
        // R4 zero-address, plus unused tail (R6)
        send(16'hFFF0); send(16'hFFFB); send(16'hFFFC); send(16'hFFFF);
        idle(4, 16'h1234);

        // Pseudo-random sweep biased toward escape prefixes
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (i % 4)
                0: send(lfsr);
                1: send({4'hF, lfsr[11:0]});
                2: send({8'hFF, lfsr[7:0]});
                default: send({12'hFFF, lfsr[3:0]});
            endcase
            if (i % 7 == 0) idle(1 + (i % 3), lfsr);
        end
        idle(4, 16'h5555);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R7 got=%0d pending expected=0 pending", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule